// File: doc/BRIEF.md
# Clock Frequency Window Checker

This block watches five slow clocks (channels io, io_div2, io_div4, main and usb, in that index order 0 to 4) from a faster reference clock. Each measured clock passes through a short synchronizer and its rising edges are counted over a fixed reference window of `WINDOW_CYCLES` cycles. When a window completes, the final count is compared with a per-channel lower and upper bound. A count outside the bounds sets a sticky error bit for that channel and pulses a recoverable alert.

Software programs each channel through a small word-wide register port. A channel's control word holds a run bit and two bound fields. The bound fields are one bit wider than the nominal count needs, which leaves room for adjustment. A shared lock bit can only be cleared. Once it is cleared, every control word is frozen until reset. Error bits are cleared by writing ones to them.

Each channel runs a three-state machine. The states are `CH_OFF` (idle, no counting), `CH_COUNT` (counting edges and reference cycles) and `CH_EVAL` (one cycle that compares the final count). The transitions are:

- OFF to COUNT when the run bit is 1.
- COUNT to OFF when the run bit is 0.
- COUNT to EVAL on the last cycle of the window.
- EVAL to COUNT when the run bit is 1; this starts a fresh window.
- EVAL to OFF when the run bit is 0.

Top module: `clk_freq_checker`

## Requirements
- R1: After reset the following hold. Every run bit reads 0. The bounds read io 470..490, io_div2 230..250, io_div4 110..130, main 490..510 and usb 230..250. The lock reads 1, the error word reads 0 and `alert_o` is 0.
- R2: Addresses 1 to 5 hold the control words of channels io, io_div2, io_div4, main and usb. In each word, bit 0 is the run bit and the upper bound sits at bits [4+W-1:4]. The lower bound sits at bits [4+2W-1:4+W], where W is 10, 9, 8, 10 and 9 for the five channels. All other bits read 0.
- R3: A running channel counts rising edges of its synchronized measured clock over `WINDOW_CYCLES` reference cycles. The count restarts at zero for each window, and one evaluation cycle separates two windows. The count saturates at 2^W-1.
- R4: A completed window is in error when its count is greater than the upper bound or less than the lower bound. A count equal to either bound is not an error.
- R5: Address 6 holds the error word, with bits 0 to 4 for channels io, io_div2, io_div4, main and usb. A bit sets in the cycle after its channel's evaluation cycle and stays set. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. If a set and a clear of the same bit fall in the same cycle, the set wins.
- R6: `alert_o` is a one-cycle pulse in the cycle after any channel's evaluation finds an error, and it is 0 at all other times.
- R7: Address 0 bit 0 is the lock. Writing 0 clears it. Writing 1 has no effect, so once cleared the lock stays 0 until reset.
- R8: While the lock is 0, writes to addresses 1 to 5 are ignored.
- R9: Clearing a channel's run bit stops its counting at once and prevents new errors from that channel. It leaves error bits that are already set. Setting the run bit again starts a fresh window.
- R10: Reads of address 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock; defines the window |
| rst_ni | input | 1 | Asynchronous active-low reset |
| meas_clk_i | input | 5 | Measured clocks, bit index = channel |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 32 | Combinational read data |
| alert_o | output | 1 | Recoverable alert pulse |

## Verification
The colliding pair is a channel's window evaluation setting its error bit and a software write-1 clearing that same bit in the same cycle. The bench provokes this by holding a write of 1 to the main channel's error bit on every cycle while main keeps failing its window. Any evaluation must therefore coincide with a clear. The per-cycle model predicts that the bit reads 1 for exactly one cycle after each failing window. The bench judges the run by counting those one-cycle highs and comparing the total with the number of alert pulses.

// File: rtl/cfc_pkg.sv
package cfc_pkg;

    localparam int unsigned NUM_CH    = 5;
    localparam int unsigned THR_W_MAX = 10;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned ADDR_W    = 3;
    localparam int unsigned FIELD_LSB = 4;

    localparam logic [ADDR_W-1:0] ADDR_LOCK      = 3'd0;
    localparam int unsigned       ADDR_CTRL_BASE = 1;
    localparam logic [ADDR_W-1:0] ADDR_ERR       = 3'd6;

    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_COUNT = 2'd1,
        CH_EVAL  = 2'd2
    } ch_state_e;

    // Bound field width per channel: io, io_div2, io_div4, main, usb
    function automatic int unsigned thr_width(input int unsigned ch);
        case (ch)
            0:       return 10;
            1:       return 9;
            2:       return 8;
            3:       return 10;
            default: return 9;
        endcase
    endfunction

    function automatic int unsigned hi_reset(input int unsigned ch);
        case (ch)
            0:       return 490;
            1:       return 250;
            2:       return 130;
            3:       return 510;
            default: return 250;
        endcase
    endfunction

    function automatic int unsigned lo_reset(input int unsigned ch);
        case (ch)
            0:       return 470;
            1:       return 230;
            2:       return 110;
            3:       return 490;
            default: return 230;
        endcase
    endfunction

endpackage

// File: rtl/cfc_edge_sync.sv
module cfc_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic rise_o
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign rise_o = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/cfc_channel.sv
module cfc_channel
    import cfc_pkg::*;
#(
    parameter int unsigned CNT_W  = 10,
    parameter int unsigned WINDOW = 1000
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 run_i,
    input  logic                 rise_i,
    input  logic [THR_W_MAX-1:0] hi_i,
    input  logic [THR_W_MAX-1:0] lo_i,
    output logic                 err_set_o
);

    localparam int unsigned       TMR_W    = (WINDOW > 2) ? $clog2(WINDOW) : 1;
    localparam logic [TMR_W-1:0]  TMR_LAST = TMR_W'(WINDOW - 1);
    localparam logic [CNT_W-1:0]  CNT_TOP  = '1;

    ch_state_e         state_q, state_d;
    logic [TMR_W-1:0]  tmr_q, tmr_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [CNT_W-1:0]  cnt_inc;
    logic              out_of_range;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= CH_OFF;
            tmr_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            tmr_q   <= tmr_d;
            cnt_q   <= cnt_d;
        end
    end

    // Saturating edge counter step
    assign cnt_inc = (rise_i && (cnt_q != CNT_TOP)) ? cnt_q + CNT_W'(1) : cnt_q;

    // Next state and datapath
    always_comb begin
        state_d = state_q;
        tmr_d   = tmr_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CH_OFF: begin
                if (run_i) begin
                    state_d = CH_COUNT;
                    tmr_d   = '0;
                    cnt_d   = '0;
                end
            end
            CH_COUNT: begin
                if (!run_i) begin
                    state_d = CH_OFF;
                    tmr_d   = '0;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_inc;
                    if (tmr_q == TMR_LAST) begin
                        state_d = CH_EVAL;
                    end else begin
                        tmr_d = tmr_q + TMR_W'(1);
                    end
                end
            end
            CH_EVAL: begin
                state_d = run_i ? CH_COUNT : CH_OFF;
                tmr_d   = '0;
                cnt_d   = '0;
            end
            default: begin
                state_d = CH_OFF;
                tmr_d   = '0;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        out_of_range = (THR_W_MAX'(cnt_q) > hi_i) || (THR_W_MAX'(cnt_q) < lo_i);
        err_set_o    = (state_q == CH_EVAL) && run_i && out_of_range;
    end

endmodule

// File: rtl/cfc_regs.sv
module cfc_regs
    import cfc_pkg::*;
(
    input  logic                                clk_i,
    input  logic                                rst_ni,
    input  logic                                wr_en_i,
    input  logic [ADDR_W-1:0]                   wr_addr_i,
    input  logic [DATA_W-1:0]                   wr_data_i,
    input  logic [ADDR_W-1:0]                   rd_addr_i,
    input  logic [NUM_CH-1:0]                   err_set_i,
    output logic [DATA_W-1:0]                   rd_data_o,
    output logic [NUM_CH-1:0]                   run_o,
    output logic [NUM_CH-1:0][THR_W_MAX-1:0]    hi_o,
    output logic [NUM_CH-1:0][THR_W_MAX-1:0]    lo_o,
    output logic                                lock_o,
    output logic [NUM_CH-1:0]                   err_o,
    output logic                                alert_o
);

    logic                            lock_q;
    logic [NUM_CH-1:0]               err_q;
    logic                            alert_q;
    logic [NUM_CH-1:0]               err_clr;
    logic [NUM_CH-1:0][DATA_W-1:0]   ctrl_word;
    logic                            unused_wdata;

    assign unused_wdata = ^wr_data_i[DATA_W-1:FIELD_LSB+2*THR_W_MAX];

    // Clear-only lock
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lock_q <= 1'b1;
        end else if (wr_en_i && (wr_addr_i == ADDR_LOCK) && !wr_data_i[0]) begin
            lock_q <= 1'b0;
        end
    end

    // Per-channel control words
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ctrl
        localparam int unsigned    W      = thr_width(ch);
        localparam logic [W-1:0]   HI_RST = W'(hi_reset(ch));
        localparam logic [W-1:0]   LO_RST = W'(lo_reset(ch));
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(ADDR_CTRL_BASE + ch);

        logic         run_q;
        logic [W-1:0] hi_q;
        logic [W-1:0] lo_q;
        logic         hit;

        assign hit = wr_en_i && lock_q && (wr_addr_i == MY_ADDR);

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                run_q <= 1'b0;
                hi_q  <= HI_RST;
                lo_q  <= LO_RST;
            end else if (hit) begin
                run_q <= wr_data_i[0];
                hi_q  <= wr_data_i[FIELD_LSB +: W];
                lo_q  <= wr_data_i[FIELD_LSB+W +: W];
            end
        end

        assign run_o[ch]     = run_q;
        assign hi_o[ch]      = THR_W_MAX'(hi_q);
        assign lo_o[ch]      = THR_W_MAX'(lo_q);
        assign ctrl_word[ch] = DATA_W'(run_q)
                             | (DATA_W'(hi_q) << FIELD_LSB)
                             | (DATA_W'(lo_q) << (FIELD_LSB + W));
    end

    // Sticky error word, set wins over clear
    assign err_clr = (wr_en_i && (wr_addr_i == ADDR_ERR)) ? wr_data_i[NUM_CH-1:0] : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            err_q   <= '0;
            alert_q <= 1'b0;
        end else begin
            err_q   <= (err_q & ~err_clr) | err_set_i;
            alert_q <= |err_set_i;
        end
    end

    // Read mux
    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == ADDR_LOCK) begin
            rd_data_o = DATA_W'(lock_q);
        end else if (rd_addr_i == ADDR_ERR) begin
            rd_data_o = DATA_W'(err_q);
        end else begin
            for (int ch = 0; ch < NUM_CH; ch++) begin
                if (rd_addr_i == ADDR_W'(ADDR_CTRL_BASE + ch)) begin
                    rd_data_o = ctrl_word[ch];
                end
            end
        end
    end

    assign lock_o  = lock_q;
    assign err_o   = err_q;
    assign alert_o = alert_q;

endmodule

// File: rtl/clk_freq_checker.sv
module clk_freq_checker
    import cfc_pkg::*;
#(
    parameter int unsigned WINDOW_CYCLES = 1000,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [4:0]        meas_clk_i,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_addr_i,
    input  logic [31:0]       wr_data_i,
    input  logic [2:0]        rd_addr_i,
    output logic [31:0]       rd_data_o,
    output logic              alert_o
);

    logic [NUM_CH-1:0]                ch_run;
    logic [NUM_CH-1:0]                ch_rise;
    logic [NUM_CH-1:0]                err_set;
    logic [NUM_CH-1:0][THR_W_MAX-1:0] thr_hi;
    logic [NUM_CH-1:0][THR_W_MAX-1:0] thr_lo;
    logic                             lock_q;
    logic [NUM_CH-1:0]                err_q;

    cfc_regs u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .err_set_i (err_set),
        .rd_data_o (rd_data_o),
        .run_o     (ch_run),
        .hi_o      (thr_hi),
        .lo_o      (thr_lo),
        .lock_o    (lock_q),
        .err_o     (err_q),
        .alert_o   (alert_o)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        cfc_edge_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .async_i (meas_clk_i[ch]),
            .rise_o  (ch_rise[ch])
        );

        cfc_channel #(
            .CNT_W  (thr_width(ch)),
            .WINDOW (WINDOW_CYCLES)
        ) u_chan (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .run_i     (ch_run[ch]),
            .rise_i    (ch_rise[ch]),
            .hi_i      (thr_hi[ch]),
            .lo_i      (thr_lo[ch]),
            .err_set_o (err_set[ch])
        );
    end

endmodule

// File: rtl/clk_freq_checker_sva.sv
module clk_freq_checker_sva
    import cfc_pkg::*;
(
    input logic                             clk_i,
    input logic                             rst_ni,
    input logic                             wr_en_i,
    input logic [2:0]                       wr_addr_i,
    input logic [31:0]                      wr_data_i,
    input logic                             lock_q,
    input logic [NUM_CH-1:0]                err_q,
    input logic [NUM_CH-1:0]                err_set,
    input logic [NUM_CH-1:0]                ch_run,
    input logic [NUM_CH-1:0][THR_W_MAX-1:0] thr_hi,
    input logic [NUM_CH-1:0][THR_W_MAX-1:0] thr_lo,
    input logic                             alert_o
);

    a_r7_lock_stays_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lock_q |=> !lock_q);

    a_r6_alert_after_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|err_set) |=> alert_o);

    a_r6_alert_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        alert_o |-> $past(|err_set));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        a_r8_ctrl_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !lock_q |=> ($stable(thr_hi[i]) && $stable(thr_lo[i]) && $stable(ch_run[i])));

        a_r5_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (err_q[i] && !(wr_en_i && (wr_addr_i == ADDR_ERR) && wr_data_i[i])) |=> err_q[i]);

        a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
            err_set[i] |=> err_q[i]);

        a_r5_rise_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(err_q[i]) |-> $past(err_set[i]));

        a_r9_idle_no_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !ch_run[i] |-> !err_set[i]);
    end

endmodule

bind clk_freq_checker clk_freq_checker_sva u_sva (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .lock_q    (lock_q),
    .err_q     (err_q),
    .err_set   (err_set),
    .ch_run    (ch_run),
    .thr_hi    (thr_hi),
    .thr_lo    (thr_lo),
    .alert_o   (alert_o)
);

// File: tb/clk_freq_checker_tb_top.sv
`timescale 1ns/1ps
module clk_freq_checker_tb_top;

    localparam int WIN = 1000;
    localparam int NCH = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  meas = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = 3'd6;
    logic [31:0] rd_data;
    logic        alert;

    int n_checks = 0;
    int n_fail = 0;
    int alert_cnt = 0;
    int seen_cnt = 0;
    bit storm = 1'b0;
    bit done = 1'b0;

    int half [NCH] = '{0, 0, 0, 0, 0};
    int ph   [NCH] = '{0, 0, 0, 0, 0};

    // Reference model state
    int wd_w   [NCH] = '{10, 9, 8, 10, 9};
    int rst_hi [NCH] = '{490, 250, 130, 510, 250};
    int rst_lo [NCH] = '{470, 230, 110, 490, 230};
    int m_s1 [NCH], m_s2 [NCH], m_prv [NCH];
    int m_st [NCH], m_tm [NCH], m_cn [NCH];
    int m_en [NCH], m_hi [NCH], m_lo [NCH];
    int m_lock = 1;
    int m_err = 0;
    int m_alert = 0;

    always #2.5 clk = ~clk;

    clk_freq_checker #(
        .WINDOW_CYCLES (WIN),
        .SYNC_STAGES   (2)
    ) dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .meas_clk_i (meas),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data),
        .alert_o    (alert)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] cw(input int en, input int hi, input int lo, input int w);
        return 32'(en) | (32'(hi) << 4) | (32'(lo) << (4 + w));
    endfunction

    function automatic logic [31:0] model_read(input int a);
        if (a == 0) return 32'(m_lock);
        if (a == 6) return 32'(m_err);
        if (a >= 1 && a <= 5) return cw(m_en[a-1], m_hi[a-1], m_lo[a-1], wd_w[a-1]);
        return 32'h0;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_s1[c] = 0; m_s2[c] = 0; m_prv[c] = 0;
            m_st[c] = 0; m_tm[c] = 0; m_cn[c] = 0;
            m_en[c] = 0; m_hi[c] = rst_hi[c]; m_lo[c] = rst_lo[c];
        end
        m_lock = 1; m_err = 0; m_alert = 0;
    endtask

    initial model_reset();

    // Measured clock generators
    always @(negedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (half[c] == 0) begin
                meas[c] <= 1'b0;
                ph[c] = 0;
            end else begin
                ph[c]++;
                if (ph[c] >= half[c]) begin
                    meas[c] <= ~meas[c];
                    ph[c] = 0;
                end
            end
        end
    end

    // Cycle-by-cycle model and comparison
    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            int set_v;
            int clr_v;
            set_v = 0;
            for (int c = 0; c < NCH; c++)
                if (m_st[c] == 2 && m_en[c] != 0 && (m_cn[c] > m_hi[c] || m_cn[c] < m_lo[c]))
                    set_v |= (1 << c);
            clr_v = (wr_en && wr_addr == 3'd6) ? int'(wr_data[4:0]) : 0;
            m_err = (m_err & ~clr_v) | set_v;
            m_alert = (set_v != 0) ? 1 : 0;
            for (int c = 0; c < NCH; c++) begin
                bit rise;
                rise = (m_s2[c] != 0) && (m_prv[c] == 0);
                case (m_st[c])
                    0: if (m_en[c] != 0) begin m_st[c] = 1; m_tm[c] = 0; m_cn[c] = 0; end
                    1: begin
                        if (m_en[c] == 0) begin
                            m_st[c] = 0; m_tm[c] = 0; m_cn[c] = 0;
                        end else begin
                            if (rise && m_cn[c] < (1 << wd_w[c]) - 1) m_cn[c]++;
                            if (m_tm[c] == WIN - 1) m_st[c] = 2;
                            else m_tm[c]++;
                        end
                    end
                    default: begin
                        m_st[c] = (m_en[c] != 0) ? 1 : 0; m_tm[c] = 0; m_cn[c] = 0;
                    end
                endcase
                m_prv[c] = m_s2[c]; m_s2[c] = m_s1[c]; m_s1[c] = int'(meas[c]);
            end
            if (wr_en) begin
                if (wr_addr == 3'd0 && !wr_data[0]) m_lock = 0;
                if (wr_addr >= 3'd1 && wr_addr <= 3'd5 && m_lock != 0) begin
                    int c;
                    c = int'(wr_addr) - 1;
                    m_en[c] = int'(wr_data[0]);
                    m_hi[c] = int'((wr_data >> 4) & ((32'd1 << wd_w[c]) - 1));
                    m_lo[c] = int'((wr_data >> (4 + wd_w[c])) & ((32'd1 << wd_w[c]) - 1));
                end
            end
        end
        #2;
        if (rst_n && !done) begin
            chk("R5 per-cycle read", rd_data, model_read(int'(rd_addr)));
            chk("R6 per-cycle alert", 32'(alert), 32'(m_alert));
            if (alert) alert_cnt++;
            if (storm && rd_addr == 3'd6 && rd_data[3]) seen_cnt++;
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = 3'(a);
        @(posedge clk);
        #1 d = rd_data;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int a0;
        repeat (6) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(0, d); chk("R1 lock reset", d, 32'd1);
        rd(1, d); chk("R1 io reset", d, (32'd470 << 14) | (32'd490 << 4));
        rd(3, d); chk("R1 io_div4 reset", d, (32'd110 << 12) | (32'd130 << 4));
        rd(4, d); chk("R1 main reset", d, (32'd490 << 14) | (32'd510 << 4));
        rd(5, d); chk("R1 usb reset", d, (32'd230 << 13) | (32'd250 << 4));
        rd(6, d); chk("R1 error reset", d, 32'd0);
        chk("R1 alert reset", 32'(alert), 32'd0);

        // R2 field layout
        wr(1, 32'hFFFF_FFFF); rd(1, d); chk("R2 io layout", d, 32'h00FF_FFF1);
        wr(3, 32'hFFFF_FFFF); rd(3, d); chk("R2 io_div4 layout", d, 32'h000F_FFF1);
        wr(1, 32'h0); wr(3, 32'h0);
        rd(7, d); chk("R10 unmapped read", d, 32'd0);

        // R3 R4 equality on main: exactly WIN/2 edges per window
        half[3] = 1;
        wr(4, cw(1, 500, 500, 10));
        repeat (3 * (WIN + 1) + 20) @(posedge clk);
        rd(6, d); chk("R4 equal bounds pass", 32'(d[3]), 32'd0);
        chk("R6 no alert on pass", 32'(alert_cnt), 32'd0);

        wr(4, cw(1, 499, 0, 10));
        repeat (2 * (WIN + 1) + 10) @(posedge clk);
        rd(6, d); chk("R4 above upper errors", 32'(d[3]), 32'd1);
        chk("R6 alert raised", 32'(alert_cnt > 0), 32'd1);

        // R9 disable keeps error, no new error
        wr(4, cw(0, 499, 0, 10));
        repeat (WIN + 100) @(posedge clk);
        rd(6, d); chk("R9 error kept after disable", 32'(d[3]), 32'd1);
        wr(6, 32'd0); rd(6, d); chk("R5 write zero no effect", 32'(d[3]), 32'd1);
        wr(6, 32'd8); rd(6, d); chk("R5 write one clears", 32'(d[3]), 32'd0);
        repeat (2 * (WIN + 1) + 10) @(posedge clk);
        rd(6, d); chk("R9 no error while off", 32'(d[3]), 32'd0);

        // R4 below lower bound
        wr(4, cw(1, 1023, 501, 10));
        repeat (2 * (WIN + 1) + 10) @(posedge clk);
        rd(6, d); chk("R4 below lower errors", 32'(d[3]), 32'd1);

        // R5 set and clear in the same cycle
        rd_addr = 3'd6;
        a0 = alert_cnt;
        seen_cnt = 0;
        @(negedge clk);
        storm = 1'b1;
        wr_en = 1'b1; wr_addr = 3'd6; wr_data = 32'd8;
        repeat (2 * (WIN + 1) + 100) @(negedge clk);
        wr_en = 1'b0;
        storm = 1'b0;
        chk("R5 collisions provoked", 32'((alert_cnt - a0) >= 2), 32'd1);
        chk("R5 set wins over clear", 32'(seen_cnt), 32'(alert_cnt - a0));
        wr(4, 32'h0); wr(6, 32'd8);

        // R3 saturation on 8-bit channel
        half[2] = 1;
        wr(3, cw(1, 255, 255, 8));
        repeat (2 * (WIN + 1) + 10) @(posedge clk);
        rd(6, d); chk("R3 saturated count passes", 32'(d[2]), 32'd0);
        wr(3, cw(1, 254, 0, 8));
        repeat (2 * (WIN + 1) + 10) @(posedge clk);
        rd(6, d); chk("R3 saturated above upper", 32'(d[2]), 32'd1);
        wr(3, 32'h0); wr(6, 32'd4);

        // R4 stopped clock gives zero count
        half[4] = 0;
        wr(5, cw(1, 0, 0, 9));
        repeat (2 * (WIN + 1) + 10) @(posedge clk);
        rd(6, d); chk("R4 zero count equal bounds", 32'(d[4]), 32'd0);
        wr(5, cw(1, 5, 1, 9));
        repeat (2 * (WIN + 1) + 10) @(posedge clk);
        rd(6, d); chk("R4 zero count below lower", 32'(d[4]), 32'd1);
        wr(5, 32'h0);

        // R7 R8 lock
        wr(0, 32'd1); rd(0, d); chk("R7 write one keeps lock", d, 32'd1);
        wr(0, 32'd0); rd(0, d); chk("R7 write zero clears", d, 32'd0);
        wr(0, 32'd1); rd(0, d); chk("R7 cannot re-arm", d, 32'd0);
        wr(1, cw(1, 7, 3, 10)); rd(1, d); chk("R8 ctrl write ignored", d, 32'd0);
        wr(6, 32'd16); rd(6, d); chk("R5 clear works when locked", d, 32'd0);

        repeat (5) @(posedge clk);
        finish_run();
    end

endmodule